// File: doc/BRIEF.md
# Pulse-Swallow Feedback Divider

This block is the programmable feedback divider of a synthesizer loop. It runs on the output clock of an external dual-modulus prescaler and counts that clock with two nested counters. These are a main counter of N prescaler cycles and a swallow counter of A cycles that shares the same period. While the swallow counter is non-zero, the block asks the prescaler for its larger modulus (P+1). After that it asks for the plain modulus P. One division period therefore spans P×N + A VCO cycles. Once the reference divider has scaled the crystal by R, the loop settles at f_vco = (P×N + A) × f_osc / R.

The counts and the prescaler-select bit come from registers that are already latched elsewhere. The block samples them only at the boundary between two periods, so a change in the middle of a period can never produce a malformed period. If a sampled setting is illegal, the block does not load it. A main count below the minimum and a swallow count larger than the main count are both illegal. The block keeps the previous setting and raises an error flag instead. Once per period it emits a single-cycle pulse, which goes to the phase comparator.

Top module: `psd_divider`

## Requirements
- R1: While rst_n is low, fp, mod_ctl, presc_sel and cfg_err are all 0. The period that follows reset uses N = RST_N (default 3), A = RST_A (default 0) and select 0.
- R2: With an accepted main count N, fp is 1 for exactly one clock cycle, the last cycle of each period. Consecutive fp pulses are N cycles apart. This holds for every N from 3 up to 2047.
- R3: In every period, mod_ctl is 1 (meaning divide by P+1) during the first A clock cycles and 0 during the remaining N−A cycles. mod_ctl rises only in the cycle right after an fp cycle.
- R4: Take P as P_BASE when the period's select is 0 and 2×P_BASE when it is 1. Summed over one period, the VCO cycles (P + mod_ctl per clock cycle) equal P×N + A.
- R5: n_in, a_in and sel_in are sampled only at the clock edge that ends an fp cycle. Changes at any other time have no effect on the period in progress.
- R6: If a_in > n_in at a sampling edge, the new setting is rejected and the previous N, A and select are kept. cfg_err is 1 from that edge until a sampling edge sees a legal setting.
- R7: If n_in < 3 at a sampling edge, the setting is rejected and cfg_err is set in the same way. This check takes priority over the check of R6.
- R8: A = 0 keeps mod_ctl at 0 for the whole period. A = N keeps it at 1 for the whole period.
- R9: presc_sel shows the select bit of the current period and changes only at a sampling edge. cfg_err also changes only at a sampling edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Prescaler output clock |
| rst_n | input | 1 | Active-low synchronous reset |
| n_in | input | N_W | Latched main count N |
| a_in | input | A_W | Latched swallow count A |
| sel_in | input | 1 | Latched prescaler-ratio select |
| mod_ctl | output | 1 | Modulus control to prescaler, 1 = P+1 |
| presc_sel | output | 1 | Ratio select applied this period |
| fp | output | 1 | One-cycle comparison pulse per period |
| cfg_err | output | 1 | Last sampled setting was rejected |

## Verification
The bound checker checks on every cycle the properties that follow from the outputs alone. It confirms that fp never lasts two cycles and that fp recurs within the largest period. It also confirms that mod_ctl rises only right after fp, and that presc_sel and cfg_err move only at period boundaries. Exact period lengths, the number of P+1 cycles, the P×N + A count of VCO cycles and the rejection of illegal settings depend on the values sampled. Only the bench's cycle-by-cycle reference model can show those, as the bench drives legal, illegal, boundary and mid-period settings.

// File: rtl/psd_pkg.sv
package psd_pkg;
   // Outcome of validating a sampled setting; short N wins over A > N.
   typedef enum logic [1:0] {
      CFG_OK        = 2'd0,
      CFG_SHORT_N   = 2'd1,
      CFG_A_ABOVE_N = 2'd2
   } cfg_stat_e;
endpackage

// File: rtl/psd_cfg_gate.sv
module psd_cfg_gate #(
   parameter int N_W   = 11,
   parameter int A_W   = 7,
   parameter int N_MIN = 3,
   parameter int RST_N = 3,
   parameter int RST_A = 0
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           load,
   input  logic [N_W-1:0] n_in,
   input  logic [A_W-1:0] a_in,
   input  logic           sel_in,
   output logic [N_W-1:0] n_nxt,
   output logic [A_W-1:0] a_nxt,
   output logic           sel_cur,
   output logic           cfg_err
);
   import psd_pkg::*;

   localparam logic [N_W-1:0] N_MIN_V = N_W'(N_MIN);

   logic [N_W-1:0] n_cur;
   logic [A_W-1:0] a_cur;
   logic [N_W-1:0] a_wide;
   cfg_stat_e      stat;
   logic           take;
   logic           sel_nxt;

   always_comb begin
      a_wide = N_W'(a_in);
      if (n_in < N_MIN_V)      stat = CFG_SHORT_N;
      else if (a_wide > n_in)  stat = CFG_A_ABOVE_N;
      else                     stat = CFG_OK;
   end

   assign take    = (stat == CFG_OK);
   assign n_nxt   = take ? n_in   : n_cur;
   assign a_nxt   = take ? a_in   : a_cur;
   assign sel_nxt = take ? sel_in : sel_cur;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         n_cur   <= N_W'(RST_N);
         a_cur   <= A_W'(RST_A);
         sel_cur <= 1'b0;
         cfg_err <= 1'b0;
      end else if (load) begin
         n_cur   <= n_nxt;
         a_cur   <= a_nxt;
         sel_cur <= sel_nxt;
         cfg_err <= !take;
      end
   end
endmodule

// File: rtl/psd_main_cnt.sv
module psd_main_cnt #(
   parameter int N_W        = 11,
   parameter int RST_N      = 3,
   parameter bit COUNT_DOWN = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [N_W-1:0] n_nxt,
   output logic           wrap
);
   localparam logic [N_W-1:0] ONE = N_W'(1);

   generate
      if (COUNT_DOWN) begin : g_down
         logic [N_W-1:0] rem;
         assign wrap = (rem == '0);
         always_ff @(posedge clk) begin
            if (!rst_n)    rem <= N_W'(RST_N - 1);
            else if (wrap) rem <= n_nxt - ONE;
            else           rem <= rem - ONE;
         end
      end else begin : g_up
         logic [N_W-1:0] idx;
         logic [N_W-1:0] lim;
         assign wrap = (idx == lim);
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               idx <= '0;
               lim <= N_W'(RST_N - 1);
            end else if (wrap) begin
               idx <= '0;
               lim <= n_nxt - ONE;
            end else begin
               idx <= idx + ONE;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/psd_swallow_cnt.sv
module psd_swallow_cnt #(
   parameter int A_W     = 7,
   parameter int RST_A   = 0,
   parameter bit MOD_REG = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           load,
   input  logic [A_W-1:0] a_nxt,
   output logic           mod_ctl
);
   localparam logic [A_W-1:0] ONE = A_W'(1);

   logic [A_W-1:0] rem;
   logic [A_W-1:0] rem_d;

   always_comb begin
      if (load)            rem_d = a_nxt;
      else if (rem != '0)  rem_d = rem - ONE;
      else                 rem_d = '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) rem <= A_W'(RST_A);
      else        rem <= rem_d;
   end

   generate
      if (MOD_REG) begin : g_reg
         logic mod_q;
         always_ff @(posedge clk) begin
            if (!rst_n) mod_q <= (RST_A != 0);
            else        mod_q <= (rem_d != '0);
         end
         assign mod_ctl = mod_q;
      end else begin : g_comb
         assign mod_ctl = (rem != '0);
      end
   endgenerate
endmodule

// File: rtl/psd_divider.sv
module psd_divider #(
   parameter int N_W        = 11,
   parameter int A_W        = 7,
   parameter int N_MIN      = 3,
   parameter int RST_N      = 3,
   parameter int RST_A      = 0,
   parameter bit COUNT_DOWN = 1'b1,
   parameter bit MOD_REG    = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [N_W-1:0] n_in,
   input  logic [A_W-1:0] a_in,
   input  logic           sel_in,
   output logic           mod_ctl,
   output logic           presc_sel,
   output logic           fp,
   output logic           cfg_err
);
   generate
      if (A_W > N_W) begin : g_bad_aw
         $error("psd_divider: A_W must not exceed N_W");
      end
      if (N_MIN < 2) begin : g_bad_min
         $error("psd_divider: N_MIN must be at least 2");
      end
      if (RST_N < N_MIN || RST_N >= (1 << N_W)) begin : g_bad_rstn
         $error("psd_divider: RST_N out of range");
      end
      if (RST_A < 0 || RST_A > RST_N || RST_A >= (1 << A_W)) begin : g_bad_rsta
         $error("psd_divider: RST_A out of range");
      end
   endgenerate

   logic           wrap;
   logic [N_W-1:0] n_nxt;
   logic [A_W-1:0] a_nxt;

   psd_cfg_gate #(
      .N_W(N_W), .A_W(A_W), .N_MIN(N_MIN), .RST_N(RST_N), .RST_A(RST_A)
   ) u_cfg (
      .clk(clk), .rst_n(rst_n), .load(wrap),
      .n_in(n_in), .a_in(a_in), .sel_in(sel_in),
      .n_nxt(n_nxt), .a_nxt(a_nxt), .sel_cur(presc_sel), .cfg_err(cfg_err)
   );

   psd_main_cnt #(
      .N_W(N_W), .RST_N(RST_N), .COUNT_DOWN(COUNT_DOWN)
   ) u_main (
      .clk(clk), .rst_n(rst_n), .n_nxt(n_nxt), .wrap(wrap)
   );

   psd_swallow_cnt #(
      .A_W(A_W), .RST_A(RST_A), .MOD_REG(MOD_REG)
   ) u_swallow (
      .clk(clk), .rst_n(rst_n), .load(wrap), .a_nxt(a_nxt), .mod_ctl(mod_ctl)
   );

   assign fp = wrap;
endmodule

// File: rtl/psd_divider_chk.sv
module psd_divider_chk #(
   parameter int N_W = 11
) (
   input logic clk,
   input logic rst_n,
   input logic fp,
   input logic mod_ctl,
   input logic presc_sel,
   input logic cfg_err
);
   localparam logic [N_W:0] GAP_LIM = {1'b1, {N_W{1'b0}}};

   logic [N_W:0] gap;
   always_ff @(posedge clk) begin
      if (!rst_n)  gap <= '0;
      else if (fp) gap <= '0;
      else if (gap != GAP_LIM) gap <= gap + 1'b1;
   end

   AST_FP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      fp |=> !fp); // R2
   AST_FP_RECURS: assert property (@(posedge clk) disable iff (!rst_n)
      gap < GAP_LIM); // R2
   AST_MOD_RISE_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mod_ctl) |-> $past(fp)); // R3
   AST_SEL_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(fp) |-> $stable(presc_sel)); // R9
   AST_ERR_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(fp) |-> $stable(cfg_err)); // R6
endmodule

bind psd_divider psd_divider_chk #(.N_W(N_W)) u_psd_chk (
   .clk(clk), .rst_n(rst_n), .fp(fp), .mod_ctl(mod_ctl),
   .presc_sel(presc_sel), .cfg_err(cfg_err)
);

// File: tb/psd_divider_bench.sv
module psd_divider_bench;
   localparam int N_W   = 11;
   localparam int A_W   = 7;
   localparam int RST_N = 3;
   localparam int PB    = 64;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [N_W-1:0] n_in = '0;
   logic [A_W-1:0] a_in = '0;
   logic           sel_in = 1'b0;
   logic           mod_ctl, presc_sel, fp, cfg_err;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   string scen = "R1 reset";

   // reference model state
   int mk, mn, ma, msel, merr, acc;
   string mcause = "R6";

   always #2 clk = ~clk;

   psd_divider #(.N_W(N_W), .A_W(A_W)) u_psd_divider (
      .clk(clk), .rst_n(rst_n), .n_in(n_in), .a_in(a_in), .sel_in(sel_in),
      .mod_ctl(mod_ctl), .presc_sel(presc_sel), .fp(fp), .cfg_err(cfg_err)
   );

   task automatic chk(input string req, input int got, input int exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s at cycle %0d: got %0d expected %0d", req, cyc, got, exp);
      end
   endtask

   task automatic finish_run();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   always @(negedge clk) begin
      int efp, emod, p;
      if (!rst_n) begin
         mk = 0; mn = RST_N; ma = 0; msel = 0; merr = 0; acc = 0;
      end else begin
         efp  = (mk == mn - 1) ? 1 : 0;
         emod = (mk < ma) ? 1 : 0;
         p    = msel ? 2 * PB : PB;
         chk({"R2 fp, ", scen}, int'(fp), efp);
         chk({"R3 mod_ctl, ", scen}, int'(mod_ctl), emod);
         chk({"R9 presc_sel, ", scen}, int'(presc_sel), msel);
         chk({mcause, " cfg_err, ", scen}, int'(cfg_err), merr);
         acc += p + int'(mod_ctl);
         if (efp) begin
            chk({"R4 vco count, ", scen}, acc, p * mn + ma);
            acc = 0;
            mk  = 0;
            if (int'(n_in) < 3) begin
               merr = 1; mcause = "R7";
            end else if (int'(a_in) > int'(n_in)) begin
               merr = 1; mcause = "R6";
            end else begin
               mn = int'(n_in); ma = int'(a_in); msel = int'(sel_in);
               merr = 0;
            end
         end else begin
            mk++;
         end
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         errors++;
         checks++;
         $display("FAIL watchdog: got %0d cycles expected completion", cyc);
         finish_run();
      end
   end

   task automatic cfg(input int n, input int a, input int s, input string tag);
      @(posedge clk);
      #1;
      n_in = N_W'(n); a_in = A_W'(a); sel_in = s[0]; scen = tag;
   endtask

   task automatic run(input int k);
      repeat (k) @(posedge clk);
   endtask

   initial begin
      n_in = 11'd5; a_in = 7'd2; sel_in = 1'b0;
      repeat (3) @(negedge clk);
      chk("R1 fp in reset", int'(fp), 0);
      chk("R1 mod_ctl in reset", int'(mod_ctl), 0);
      chk("R1 presc_sel in reset", int'(presc_sel), 0);
      chk("R1 cfg_err in reset", int'(cfg_err), 0);
      @(posedge clk);
      #1 rst_n = 1'b1;
      scen = "R2 basic";
      run(30);
      cfg(9, 0, 0, "R8 A zero");            run(40);
      cfg(6, 6, 1, "R8 A equals N");        run(30);
      cfg(3, 3, 0, "R8 min N full swallow"); run(20);
      cfg(20, 7, 1, "R4 select high");       run(80);
      cfg(10, 11, 0, "R6 A above N");        run(40);
      cfg(10, 4, 0, "R6 recovery");          run(30);
      cfg(2, 0, 1, "R7 N below min");        run(30);
      cfg(0, 0, 0, "R7 N zero");             run(20);
      cfg(1, 5, 1, "R7 priority over A");    run(20);
      cfg(4, 1, 1, "R7 recovery");           run(20);
      for (int i = 0; i < 24; i++) begin
         int n;
         n = 4 + (i * 7) % 13;
         cfg(n, (i * 5) % (n + 1), i % 2, "R5 mid-period change");
         run(3 + (i % 5));
      end
      run(40);
      cfg(2047, 127, 1, "R2 max N");         run(4200);
      cfg(127, 127, 0, "R8 max A equals N"); run(300);
      finish_run();
   end
endmodule